// File: doc/BRIEF.md
# SPI Serial EEPROM Sequential Word Reader

This block is an SPI master that fetches a run of 16-bit words from a serial EEPROM. A host gives a start word offset, a word count and the address width of the attached part. The block first polls the device status until the device reports that it is idle. It then sends one read command and clocks in every requested word back-to-back, while the device advances its own internal address. Each word goes out on a valid/ready port. The first byte received from the device becomes the low byte of the word.

The serial clock runs in mode 0. Outgoing bits change while the clock is low, and the incoming line is sampled on the rising clock edge. The status poll is bounded by a budget of poll attempts. When the budget runs out, the block releases the device and raises a timeout flag. Clock rate, chip-select settle delay, wait between polls and poll budget are parameters counted in system clocks, so a short simulation can use small values.

Top module: `spi_eeprom_seq_reader`

## Requirements
- R1: After reset spi_cs_no is 1, and spi_sck_o, spi_mosi_o, busy_o, word_valid_o, done_o and err_o are 0.
- R2: Serial mode 0. Bits go out MSB first. spi_mosi_o changes only while spi_sck_o is low, and spi_miso_i is sampled on the rising edge of spi_sck_o.
- R3: Before reading, the block sends opcode 0x05 and then clocks in a status byte. It repeats this while status bit 0 is 1, and continues only once bit 0 is 0. The number of polls is the number of busy results plus one.
- R4: Between two commands, spi_cs_no goes high for exactly DELAY_CYC clocks and then low for DELAY_CYC clocks. spi_sck_o is never high while spi_cs_no is high.
- R5: If POLL_MAX consecutive polls all report busy, the block drives spi_cs_no high, sets err_o, delivers no words and sends no read command. err_o stays set until the next accepted start.
- R6: With addr16_i = 1, the read command is opcode 0x03 followed by a 16-bit byte address equal to twice the word offset (low 16 bits), sent MSB first.
- R7: With addr16_i = 0, the address is one byte, the low 8 bits of twice the word offset. The opcode is 0x0B (0x03 with bit 3 set) when the offset is 128 or more, and 0x03 otherwise.
- R8: One transfer sends exactly one read command and returns exactly count_i words. The words come from consecutive device bytes, following the device's own address wrap at its end.
- R9: word_o holds the second received byte in bits 15:8 and the first received byte in bits 7:0.
- R10: While word_valid_o is 1 and word_ready_i is 0, word_o and word_valid_o hold, and spi_sck_o stays low.
- R11: After the last word is accepted, or after a timeout, spi_cs_no goes high and spi_sck_o stays low for DELAY_CYC clocks. done_o then pulses for one clock and busy_o falls. busy_o is 1 from the clock after an accepted start.
- R12: A start with count_i = 0 is ignored, and so is a start while busy_o is 1.
- R13: A ready status on the last allowed poll (poll number POLL_MAX) proceeds to the read with err_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transfer (accepted when idle and count nonzero) |
| addr16_i | input | 1 | 1: 16-bit address field, 0: 8-bit address field |
| offset_i | input | OFS_W | Start word offset |
| count_i | input | CNT_W | Number of words to read |
| busy_o | output | 1 | Transfer in progress |
| word_o | output | 16 | Assembled, byte-swapped word |
| word_valid_o | output | 1 | word_o is valid |
| word_ready_i | input | 1 | Host accepts word_o |
| done_o | output | 1 | One-clock pulse at the end of a transfer |
| err_o | output | 1 | Status poll timed out |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to device |
| spi_miso_i | input | 1 | Serial data from device |

## Verification
The final status poll can report ready in the same step in which the poll budget runs out. The design has to let the ready result win over the timeout. The bench drives this case with a device model that stays busy for exactly POLL_MAX-1 polls, and again for POLL_MAX polls. It judges the outcome by err_o, by the number of polls the model counts and by whether correct data follows. Host backpressure on the word port is mixed in at random. This checks that serial clocking pauses cleanly between words.

// File: rtl/eep_rd_pkg.sv
package eep_rd_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_A8   = 8'h08;
  localparam int         CMD_W   = 24;
  localparam int         WORD_W  = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACQ,
    ST_POLL_TX,
    ST_POLL_RX,
    ST_POLL_WAIT,
    ST_GAP_HI,
    ST_GAP_LO,
    ST_CMD,
    ST_DATA,
    ST_HOLD,
    ST_REL
  } rd_state_e;
endpackage

// File: rtl/eep_timer.sv
module eep_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eep_bit_engine.sv
module eep_bit_engine #(
  parameter int HALF_CYC = 2,
  parameter int TX_W     = 24,
  parameter int RX_W     = 16,
  parameter int NB_W     = $clog2(TX_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NB_W-1:0] nbits_i,
  input  logic [TX_W-1:0] tx_i,
  input  logic            miso_i,
  output logic            sck_o,
  output logic            mosi_o,
  output logic            done_o,
  output logic [RX_W-1:0] rx_o
);
  localparam int HC_W = $clog2(HALF_CYC + 1);
  localparam logic [HC_W-1:0] HC_M1 = HC_W'(HALF_CYC - 1);

  logic            act_q, sck_q, done_q;
  logic [NB_W-1:0] left_q;
  logic [HC_W-1:0] hc_q;
  logic [TX_W-1:0] tx_q;
  logic [RX_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      left_q <= '0;
      hc_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start_i) begin
          act_q  <= 1'b1;
          sck_q  <= 1'b0;
          tx_q   <= tx_i;
          left_q <= nbits_i;
          hc_q   <= HC_M1;
        end
      end else if (hc_q != '0) begin
        hc_q <= hc_q - 1'b1;
      end else begin
        hc_q <= HC_M1;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[RX_W-2:0], miso_i};   // sample on rising edge
        end else begin
          sck_q <= 1'b0;
          if (left_q == NB_W'(1)) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
            tx_q   <= {tx_q[TX_W-2:0], 1'b0};  // next bit while clock low
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = act_q & tx_q[TX_W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R2: data out never moves while the clock is high
  a_r2_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o));
endmodule

// File: rtl/spi_eeprom_seq_reader.sv
module spi_eeprom_seq_reader
  import eep_rd_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int CNT_W     = 16,
  parameter int HALF_CYC  = 4,
  parameter int DELAY_CYC = 200,
  parameter int STEP_CYC  = 1000,
  parameter int POLL_MAX  = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             addr16_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic [15:0]      word_o,
  output logic             word_valid_o,
  input  logic             word_ready_i,
  output logic             done_o,
  output logic             err_o,
  output logic             spi_cs_no,
  output logic             spi_sck_o,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i
);
  localparam int TMR_MAX = (DELAY_CYC > STEP_CYC) ? DELAY_CYC : STEP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PL_W    = $clog2(POLL_MAX + 1);
  localparam int NB_W    = $clog2(CMD_W + 1);
  localparam logic [TMR_W-1:0] DLY_M1  = TMR_W'(DELAY_CYC - 1);
  localparam logic [TMR_W-1:0] STEP_M1 = TMR_W'(STEP_CYC - 1);
  localparam logic [NB_W-1:0]  NB_BYTE = NB_W'(8);
  localparam logic [NB_W-1:0]  NB_WORD = NB_W'(WORD_W);

  rd_state_e state_q, state_d;
  logic [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] left_q;
  logic [PL_W-1:0]  polls_q;
  logic             a16_q, go_rd_q, err_q;

  logic             eng_start, eng_done;
  logic [NB_W-1:0]  eng_n;
  logic [CMD_W-1:0] eng_tx;
  logic [WORD_W-1:0] eng_rx;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;

  logic [OFS_W:0]   byte_addr;
  logic [7:0]       op_rd;
  logic [CMD_W-1:0] cmd_word;
  logic [NB_W-1:0]  cmd_bits;
  logic             accept, poll_busy, last_poll;

  assign accept    = (state_q == ST_IDLE) && start_i && (count_i != '0);
  assign poll_busy = eng_rx[0];
  assign last_poll = (polls_q == PL_W'(POLL_MAX - 1));

  assign byte_addr = {ofs_q, 1'b0};
  assign op_rd     = OP_READ | ((!a16_q && (ofs_q >= OFS_W'(128))) ? OP_A8 : 8'h00);
  assign cmd_word  = a16_q ? {op_rd, byte_addr[15:0]} : {op_rd, byte_addr[7:0], 8'h00};
  assign cmd_bits  = a16_q ? NB_W'(24) : NB_W'(16);

  always_comb begin
    state_d   = state_q;
    eng_start = 1'b0;
    eng_tx    = '0;
    eng_n     = NB_BYTE;
    tmr_load  = 1'b0;
    tmr_val   = DLY_M1;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_ACQ;
        tmr_load = 1'b1;
      end
      ST_ACQ: if (tmr_zero) begin
        eng_start = 1'b1;
        eng_tx    = {OP_RDSR, 16'h0000};
        state_d   = ST_POLL_TX;
      end
      ST_POLL_TX: if (eng_done) begin
        eng_start = 1'b1;
        state_d   = ST_POLL_RX;
      end
      ST_POLL_RX: if (eng_done) begin
        tmr_load = 1'b1;
        if (!poll_busy)     state_d = ST_GAP_HI;
        else if (last_poll) state_d = ST_REL;
        else begin
          state_d = ST_POLL_WAIT;
          tmr_val = STEP_M1;
        end
      end
      ST_POLL_WAIT: if (tmr_zero) begin
        state_d  = ST_GAP_HI;
        tmr_load = 1'b1;
      end
      ST_GAP_HI: if (tmr_zero) begin
        state_d  = ST_GAP_LO;
        tmr_load = 1'b1;
      end
      ST_GAP_LO: if (tmr_zero) begin
        eng_start = 1'b1;
        if (go_rd_q) begin
          eng_tx  = cmd_word;
          eng_n   = cmd_bits;
          state_d = ST_CMD;
        end else begin
          eng_tx  = {OP_RDSR, 16'h0000};
          state_d = ST_POLL_TX;
        end
      end
      ST_CMD: if (eng_done) begin
        eng_start = 1'b1;
        eng_n     = NB_WORD;
        state_d   = ST_DATA;
      end
      ST_DATA: if (eng_done) state_d = ST_HOLD;
      ST_HOLD: if (word_ready_i) begin
        if (left_q == CNT_W'(1)) begin
          state_d  = ST_REL;
          tmr_load = 1'b1;
        end else begin
          eng_start = 1'b1;
          eng_n     = NB_WORD;
          state_d   = ST_DATA;
        end
      end
      ST_REL: if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ofs_q   <= '0;
      left_q  <= '0;
      polls_q <= '0;
      a16_q   <= 1'b0;
      go_rd_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ofs_q   <= offset_i;
        left_q  <= count_i;
        a16_q   <= addr16_i;
        polls_q <= '0;
        go_rd_q <= 1'b0;
        err_q   <= 1'b0;
      end
      if (state_q == ST_POLL_RX && eng_done) begin
        if (!poll_busy)      go_rd_q <= 1'b1;
        else if (last_poll)  err_q   <= 1'b1;
        else                 polls_q <= polls_q + 1'b1;
      end
      if (state_q == ST_HOLD && word_ready_i && left_q != CNT_W'(1))
        left_q <= left_q - 1'b1;
    end
  end

  eep_timer #(.W(TMR_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  eep_bit_engine #(
    .HALF_CYC (HALF_CYC),
    .TX_W     (CMD_W),
    .RX_W     (WORD_W),
    .NB_W     (NB_W)
  ) i_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .nbits_i (eng_n),
    .tx_i    (eng_tx),
    .miso_i  (spi_miso_i),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .done_o  (eng_done),
    .rx_o    (eng_rx)
  );

  assign busy_o       = (state_q != ST_IDLE);
  assign spi_cs_no    = (state_q == ST_IDLE) || (state_q == ST_GAP_HI) || (state_q == ST_REL);
  assign word_valid_o = (state_q == ST_HOLD);
  assign word_o       = {eng_rx[7:0], eng_rx[15:8]};
  assign done_o       = (state_q == ST_REL) && tmr_zero;
  assign err_o        = err_q;

  a_r4_sck_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> !spi_cs_no);
  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_o));
  a_r10_hold_sck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !spi_sck_o && !spi_cs_no);
  a_r5_err_cs_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> spi_cs_no && !word_valid_o);
  a_r3_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polls_q < PL_W'(POLL_MAX));
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && spi_cs_no && !spi_sck_o);
endmodule

// File: tb/test_spi_eeprom_seq_reader.sv
`timescale 1ns/1ps
module test_spi_eeprom_seq_reader;
  localparam int HALF = 2;
  localparam int DLY  = 3;
  localparam int STEP = 4;
  localparam int POLL = 6;
  localparam int WD   = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, addr16_i = 1'b0, word_ready_i = 1'b0;
  logic [15:0] offset_i = '0, count_i = '0;
  logic busy_o, word_valid_o, done_o, err_o, spi_cs_no, spi_sck_o, spi_mosi_o;
  logic [15:0] word_o;
  logic spi_miso_i = 1'b0;

  always #2.5 clk = ~clk;

  spi_eeprom_seq_reader #(
    .HALF_CYC(HALF), .DELAY_CYC(DLY), .STEP_CYC(STEP), .POLL_MAX(POLL)
  ) i_spi_eeprom_seq_reader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr16_i(addr16_i),
    .offset_i(offset_i), .count_i(count_i), .busy_o(busy_o), .word_o(word_o),
    .word_valid_o(word_valid_o), .word_ready_i(word_ready_i), .done_o(done_o),
    .err_o(err_o), .spi_cs_no(spi_cs_no), .spi_sck_o(spi_sck_o),
    .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i)
  );

  int tests = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- EEPROM model ----------------
  logic [7:0] mem [512];
  bit   tb_a16, never_rdy;
  int   busy_left, m_polls, m_rdcmds, bitn;
  logic [7:0]  m_op, m_sr;
  logic [15:0] m_adr;
  logic [8:0]  m_ptr;

  function automatic int abits();
    return tb_a16 ? 16 : 8;
  endfunction
  function automatic bit is_rd(input logic [7:0] op);
    return (op == 8'h03) || (!tb_a16 && op == 8'h0B);
  endfunction

  always @(negedge spi_cs_no) begin
    bitn = 0; m_op = '0; m_adr = '0;
  end

  always @(posedge spi_sck_o) if (!spi_cs_no) begin
    if (bitn < 8) m_op = {m_op[6:0], spi_mosi_o};
    else if (is_rd(m_op) && bitn < 8 + abits()) m_adr = {m_adr[14:0], spi_mosi_o};
    bitn++;
    if (bitn == 8 && m_op == 8'h05) begin
      m_polls++;
      m_sr = (never_rdy || busy_left > 0) ? 8'hA5 : 8'hA4;
      if (busy_left > 0) busy_left--;
    end
    if (is_rd(m_op) && bitn == 8 + abits()) begin
      m_rdcmds++;
      m_ptr = tb_a16 ? m_adr[8:0] : {m_op[3], m_adr[7:0]};
    end
  end

  always @(negedge spi_sck_o) if (!spi_cs_no) begin
    if (m_op == 8'h05 && bitn >= 8) spi_miso_i = m_sr[7 - ((bitn - 8) % 8)];
    else if (is_rd(m_op) && bitn >= 8 + abits()) begin
      int idx;
      logic [8:0] p;
      idx = bitn - 8 - abits();
      p = m_ptr + 9'(idx / 8);
      spi_miso_i = mem[p][7 - (idx % 8)];
    end
  end

  // CS-high run monitor during a transfer
  int hi_run = 0, gap_bad = 0;
  always @(negedge clk) begin
    if (busy_o && spi_cs_no) hi_run++;
    else begin
      if (hi_run > 0 && hi_run != DLY) gap_bad++;
      hi_run = 0;
    end
  end

  function automatic logic [15:0] exp_word(input int off, input int k);
    logic [8:0] b;
    b = 9'(2 * off + 2 * k);
    return {mem[b + 9'd1], mem[b]};
  endfunction

  task automatic xfer(input bit a16, input int off, input int cnt, input int nbusy,
                      input bit never, input bit poke, input bit rnd);
    int k = 0, n = 0, exp_polls;
    bit seen_done = 0, pv = 0, pr = 0, exp_err;
    logic [15:0] pw = '0;
    logic [7:0]  e_op;
    logic [15:0] e_adr, ba;
    exp_err   = never || (nbusy >= POLL);
    exp_polls = exp_err ? POLL : nbusy + 1;
    ba        = 16'(2 * off);
    e_op      = (!a16 && off >= 128) ? 8'h0B : 8'h03;
    e_adr     = a16 ? ba : {8'h00, ba[7:0]};
    tb_a16 = a16; busy_left = nbusy; never_rdy = never;
    m_polls = 0; m_rdcmds = 0; gap_bad = 0;
    @(negedge clk);
    start_i = 1; addr16_i = a16; offset_i = 16'(off); count_i = 16'(cnt); word_ready_i = 0;
    @(negedge clk);
    start_i = 0;
    chk(busy_o === 1'b1, "R11", "busy after start", busy_o, 1);
    chk(err_o === 1'b0, "R5", "err cleared at start", err_o, 0);
    while (!seen_done && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 20) begin start_i = 1; offset_i = 16'(off + 5); end
      else start_i = 0;
      if (pv && !pr) begin
        chk(word_valid_o === 1'b1 && word_o === pw, "R10", "hold while not ready", word_o, pw);
      end
      if (word_valid_o) chk(spi_sck_o === 1'b0, "R10", "sck low in hold", spi_sck_o, 0);
      word_ready_i = rnd ? (($urandom % 3) != 0) : 1'b1;
      if (word_valid_o && word_ready_i) begin
        chk(word_o === exp_word(off, k), "R9 R8", "word data", word_o, exp_word(off, k));
        k++;
      end
      pv = word_valid_o; pr = word_ready_i; pw = word_o;
      if (done_o) seen_done = 1;
    end
    word_ready_i = 0;
    @(negedge clk);
    chk(seen_done, "R11", "done pulse", seen_done, 1);
    chk(busy_o === 1'b0 && spi_cs_no === 1'b1, "R11", "idle after done", {busy_o, spi_cs_no}, 2'b01);
    chk(k == (exp_err ? 0 : cnt), "R8", "word count", k, exp_err ? 0 : cnt);
    chk(m_rdcmds == (exp_err ? 0 : 1), "R8", "read commands", m_rdcmds, exp_err ? 0 : 1);
    chk(m_polls == exp_polls, exp_err ? "R5" : "R3 R13", "status polls", m_polls, exp_polls);
    chk(err_o === exp_err, "R5 R13", "timeout flag", err_o, exp_err);
    chk(gap_bad == 0, "R4", "cs high width", gap_bad, 0);
    if (!exp_err) begin
      chk(m_op == e_op, a16 ? "R2 R6" : "R2 R7", "read opcode", m_op, e_op);
      chk(m_adr == e_adr, a16 ? "R6" : "R7", "address", m_adr, e_adr);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
    m_polls = 0; m_rdcmds = 0; bitn = 0; busy_left = 0; never_rdy = 0; tb_a16 = 1;
    repeat (3) @(negedge clk);
    chk(spi_cs_no === 1'b1 && spi_sck_o === 1'b0 && spi_mosi_o === 1'b0, "R1", "spi pins in reset",
        {spi_cs_no, spi_sck_o, spi_mosi_o}, 3'b100);
    chk(busy_o === 1'b0 && word_valid_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0, "R1",
        "status in reset", {busy_o, word_valid_o, done_o, err_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // R12: zero count ignored
    start_i = 1; count_i = 0; offset_i = 16'd4;
    @(negedge clk); start_i = 0;
    repeat (8) @(negedge clk);
    chk(busy_o === 1'b0 && spi_cs_no === 1'b1 && m_polls == 0, "R12", "zero count ignored",
        {busy_o, spi_cs_no}, 2'b01);

    xfer(1, 10, 4, 0, 0, 0, 0);        // plain 16-bit
    xfer(1, 255, 3, 2, 0, 0, 1);       // wrap at device end (R8)
    xfer(0, 130, 2, 1, 0, 0, 1);       // R7 upper-half opcode
    xfer(0, 127, 3, 0, 0, 0, 1);       // crossing 128 under one command
    xfer(0, 5, 2, 0, 0, 0, 0);         // R7 lower half
    xfer(1, 40, 5, 1, 0, 1, 1);        // R12 start while busy ignored
    xfer(1, 20, 2, POLL, 0, 0, 0);     // R5 budget exhausted
    xfer(1, 21, 2, POLL - 1, 0, 0, 1); // R13 ready on last poll
    xfer(0, 60, 1, 0, 1, 0, 0);        // R5 never ready
    xfer(0, 61, 2, 0, 0, 0, 0);        // err cleared by next start

    for (int t = 0; t < 20; t++) begin
      xfer(bit'($urandom % 2), int'($urandom % 256), int'($urandom % 8) + 1,
           int'($urandom % 4), 0, 0, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule